// File: doc/BRIEF.md
# DRAM refresh controller

This block keeps an asynchronous fast-page-mode DRAM alive. An interval timer, loaded from a programmable cycle count, posts a refresh request at a fixed rate. Requests that cannot be served at once are stored in a small saturating backlog. The controller asks the access sequencer for the DRAM strobes through a request/grant handshake. Once it holds the grant, it runs one refresh cycle per stored request, back to back. It hands the strobes back, both high, after the last precharge.

Each refresh cycle takes one of two forms. In the first, column strobe falls before row strobe, and the DRAM's own counter picks the row. In the second, only the row strobe pulses while the controller drives the row address from its own counter, which steps once per cycle and wraps at 2,048 or 4,096 rows depending on the array size. On command the block also enters self refresh. It holds both strobes low past a minimum width. On exit it waits out a longer precharge and then sweeps every row in one burst before it releases the strobes.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, refReq and addrDrive are low, selfActive is low, rasN and casN are high, and rowAddr is 0.
- R2: With refreshEn high and intervalCycles = N (N >= 1), refReq first rises N+1 cycles after refreshEn is raised, counted from a timer at rest. While refreshEn is low, no timer request is made and the timer restarts from zero.
- R3: rasN and casN stay high until refGnt is seen while refReq is high. Neither strobe is ever low unless refReq and refGnt are both high.
- R4: A column-first refresh drives casN low for exactly CSR_CYC cycles before rasN falls, then holds rasN low for exactly RAS_CYC cycles. weN and oeN stay high at all times.
- R5: When useRasOnly is 1, a refresh keeps casN high and holds rasN low for RAS_CYC cycles with addrDrive high and rowAddr on the bus. rowAddr steps by one after each such cycle. It wraps to 0 after 2,047 when mode4k = 0 and after 4,095 when mode4k = 1.
- R6: Up to PEND_MAX missed requests are stored, and further ones are dropped. All stored requests are served back to back under a single refReq assertion, with at least RP_CYC high cycles on rasN between cycles.
- R7: After the last cycle, rasN and casN stay high for exactly RP_CYC cycles with refReq still high. refReq then falls.
- R8: When selfReq is high in idle, the controller starts a column-first cycle and holds rasN and casN low, with selfActive high, for at least SELF_CYC cycles and for as long as selfReq stays high.
- R9: On leaving self refresh, rasN stays high for RPS_CYC cycles before the next strobe activity. A burst of exactly one cycle per row then follows, using the method selected by useRasOnly, before the strobes are released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| refreshEn | input | 1 | Enables the interval timer and timed refresh |
| intervalCycles | input | IV_W | Clock cycles between timer requests (0 acts as 1) |
| mode4k | input | 1 | 1: 4,096 rows, 0: 2,048 rows |
| useRasOnly | input | 1 | 1: row-strobe-only refresh with external row counter, 0: column-first refresh |
| selfReq | input | 1 | Level command to enter and stay in self refresh |
| refGnt | input | 1 | Grant of the strobes from the access sequencer |
| refReq | output | 1 | Request for, and ownership of, the strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, held high |
| oeN | output | 1 | Output enable, held high |
| addrDrive | output | 1 | Row address must be driven onto the DRAM address bus |
| rowAddr | output | ROW_W | Row address for row-strobe-only refresh |
| selfActive | output | 1 | Strobes are held in self refresh |

## Verification
Every output is sampled on the falling clock edge. Each count of timing is the number of consecutive falling-edge samples in which a strobe holds its level. With refreshEn raised and interval N, refReq is due at the (N+1)th sample. Column strobe falls on the first sample after grant. Row strobe follows exactly CSR_CYC samples later and stays low RAS_CYC samples. refReq drops after exactly RP_CYC high samples. A short self-refresh command yields exactly SELF_CYC low samples, followed by RPS_CYC high samples (plus CSR_CYC for a column-first burst). Backlog and burst scenarios leave the bench idle long enough to hold the timer off the next tick, so the cycle counts are exact rather than bounded.

// File: rtl/refr_pkg.sv
package refr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_CAS_SETUP,
    ST_RAS_LOW,
    ST_PRECH,
    ST_SELF_HOLD,
    ST_SELF_EXIT
  } refState_t;

  typedef enum logic [2:0] {
    PH_CSR,
    PH_RAS,
    PH_RP,
    PH_SELF,
    PH_RPS
  } phaseSel_t;

  // strobes from control to datapath
  typedef struct packed {
    logic      phaseLoad;
    phaseSel_t phaseSel;
    logic      pendDec;
    logic      pendClear;
    logic      rowInc;
    logic      burstLoad;
    logic      burstDec;
    logic      timerHold;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic phaseDone;
    logic pendAny;
    logic burstDone;
  } dpStat_t;

endpackage

// File: rtl/refr_datapath.sv
module refr_datapath
  import refr_pkg::*;
#(
  parameter int ROWS_SMALL = 2048,
  parameter int ROWS_LARGE = 4096,
  parameter int IV_W       = 16,
  parameter int PEND_MAX   = 4,
  parameter int CSR_CYC    = 2,
  parameter int RAS_CYC    = 4,
  parameter int RP_CYC     = 3,
  parameter int SELF_CYC   = 10,
  parameter int RPS_CYC    = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          refreshEn,
  input  logic [IV_W-1:0]               intervalCycles,
  input  logic                          mode4k,
  input  dpCtrl_t                       ctl,
  output dpStat_t                       stat,
  output logic [$clog2(ROWS_LARGE)-1:0] rowAddr
);

  localparam int ROW_W   = $clog2(ROWS_LARGE);
  localparam int BURST_W = ROW_W + 1;
  localparam int PEND_W  = $clog2(PEND_MAX + 1);
  localparam int MAX_A   = (CSR_CYC > RAS_CYC) ? CSR_CYC : RAS_CYC;
  localparam int MAX_B   = (RP_CYC > SELF_CYC) ? RP_CYC : SELF_CYC;
  localparam int MAX_C   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int PH_MAX  = (MAX_C > RPS_CYC) ? MAX_C : RPS_CYC;
  localparam int PH_W    = $clog2(PH_MAX + 1);

  // interval timer
  logic [IV_W-1:0] timerCnt;
  logic [IV_W-1:0] ivEff;
  logic [IV_W:0]   timerNext;
  logic            timerRun;
  logic            tick;

  assign ivEff     = (intervalCycles == '0) ? IV_W'(1) : intervalCycles;
  assign timerRun  = refreshEn && !ctl.timerHold;
  assign timerNext = {1'b0, timerCnt} + 1'b1;
  assign tick      = timerRun && (timerNext >= {1'b0, ivEff});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          timerCnt <= '0;
    else if (!timerRun) timerCnt <= '0;
    else if (tick)      timerCnt <= '0;
    else                timerCnt <= timerNext[IV_W-1:0];
  end

  // backlog of missed requests
  logic [PEND_W-1:0] pendCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendCnt <= '0;
    else if (ctl.pendClear) pendCnt <= '0;
    else begin
      case ({tick, ctl.pendDec})
        2'b10:   if (pendCnt != PEND_W'(PEND_MAX)) pendCnt <= pendCnt + 1'b1;
        2'b01:   if (pendCnt != '0) pendCnt <= pendCnt - 1'b1;
        default: pendCnt <= pendCnt;
      endcase
    end
  end

  // phase timer for strobe widths
  logic [PH_W-1:0] phaseCnt;
  logic [PH_W-1:0] durVal;

  always_comb begin
    case (ctl.phaseSel)
      PH_CSR:  durVal = PH_W'(CSR_CYC);
      PH_RAS:  durVal = PH_W'(RAS_CYC);
      PH_SELF: durVal = PH_W'(SELF_CYC);
      PH_RPS:  durVal = PH_W'(RPS_CYC);
      default: durVal = PH_W'(RP_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= '0;
    else if (ctl.phaseLoad)   phaseCnt <= durVal - 1'b1;
    else if (phaseCnt != '0)  phaseCnt <= phaseCnt - 1'b1;
  end

  // row counter for row-strobe-only refresh
  logic [ROW_W-1:0] rowCnt;
  logic [ROW_W-1:0] rowLast;

  assign rowLast = mode4k ? ROW_W'(ROWS_LARGE - 1) : ROW_W'(ROWS_SMALL - 1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rowCnt <= '0;
    else if (ctl.rowInc) rowCnt <= (rowCnt == rowLast) ? '0 : rowCnt + 1'b1;
  end

  // burst length after self refresh
  logic [BURST_W-1:0] burstLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) burstLeft <= '0;
    else if (ctl.burstLoad)
      burstLeft <= mode4k ? BURST_W'(ROWS_LARGE) : BURST_W'(ROWS_SMALL);
    else if (ctl.burstDec && burstLeft != '0)
      burstLeft <= burstLeft - 1'b1;
  end

  assign stat.phaseDone = (phaseCnt == '0);
  assign stat.pendAny   = (pendCnt != '0);
  assign stat.burstDone = (burstLeft == '0);
  assign rowAddr        = rowCnt;

endmodule

// File: rtl/refr_control.sv
module refr_control
  import refr_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    refreshEn,
  input  logic    useRasOnly,
  input  logic    selfReq,
  input  logic    refGnt,
  input  dpStat_t stat,
  output dpCtrl_t ctl,
  output logic    refReq,
  output logic    rasN,
  output logic    casN,
  output logic    addrDrive,
  output logic    selfActive
);

  refState_t state, stateN;
  logic      selfPath, selfPathN;
  logic      burstMode, burstModeN;
  logic      cycRo, cycRoN;
  refState_t startState;
  phaseSel_t startSel;

  assign startState = useRasOnly ? ST_RAS_LOW : ST_CAS_SETUP;
  assign startSel   = useRasOnly ? PH_RAS : PH_CSR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      selfPath  <= 1'b0;
      burstMode <= 1'b0;
      cycRo     <= 1'b0;
    end else begin
      state     <= stateN;
      selfPath  <= selfPathN;
      burstMode <= burstModeN;
      cycRo     <= cycRoN;
    end
  end

  always_comb begin
    stateN        = state;
    selfPathN     = selfPath;
    burstModeN    = burstMode;
    cycRoN        = cycRo;
    ctl           = '0;
    ctl.timerHold = selfPath | burstMode;
    case (state)
      ST_IDLE: begin
        if (selfReq) begin
          stateN    = ST_REQ;
          selfPathN = 1'b1;
        end else if (refreshEn && stat.pendAny) begin
          stateN = ST_REQ;
        end
      end
      ST_REQ: begin
        if (refGnt) begin
          ctl.phaseLoad = 1'b1;
          if (selfPath) begin
            stateN       = ST_CAS_SETUP;
            ctl.phaseSel = PH_CSR;
            cycRoN       = 1'b0;
          end else begin
            stateN       = startState;
            ctl.phaseSel = startSel;
            cycRoN       = useRasOnly;
          end
        end
      end
      ST_CAS_SETUP: begin
        if (stat.phaseDone) begin
          ctl.phaseLoad = 1'b1;
          if (selfPath) begin
            stateN       = ST_SELF_HOLD;
            ctl.phaseSel = PH_SELF;
          end else begin
            stateN       = ST_RAS_LOW;
            ctl.phaseSel = PH_RAS;
          end
        end
      end
      ST_RAS_LOW: begin
        if (stat.phaseDone) begin
          stateN        = ST_PRECH;
          ctl.phaseLoad = 1'b1;
          ctl.phaseSel  = PH_RP;
          ctl.burstDec  = burstMode;
          ctl.pendDec   = !burstMode;
          ctl.rowInc    = cycRo;
        end
      end
      ST_PRECH: begin
        if (stat.phaseDone) begin
          if (burstMode) begin
            if (stat.burstDone) begin
              stateN        = ST_IDLE;
              burstModeN    = 1'b0;
              ctl.pendClear = 1'b1;
            end else begin
              stateN        = startState;
              ctl.phaseLoad = 1'b1;
              ctl.phaseSel  = startSel;
              cycRoN        = useRasOnly;
            end
          end else if (refreshEn && stat.pendAny) begin
            stateN        = startState;
            ctl.phaseLoad = 1'b1;
            ctl.phaseSel  = startSel;
            cycRoN        = useRasOnly;
          end else begin
            stateN = ST_IDLE;
          end
        end
      end
      ST_SELF_HOLD: begin
        if (stat.phaseDone && !selfReq) begin
          stateN        = ST_SELF_EXIT;
          ctl.phaseLoad = 1'b1;
          ctl.phaseSel  = PH_RPS;
        end
      end
      ST_SELF_EXIT: begin
        if (stat.phaseDone) begin
          selfPathN     = 1'b0;
          burstModeN    = 1'b1;
          ctl.burstLoad = 1'b1;
          stateN        = startState;
          ctl.phaseLoad = 1'b1;
          ctl.phaseSel  = startSel;
          cycRoN        = useRasOnly;
        end
      end
      default: stateN = ST_IDLE;
    endcase
  end

  assign refReq     = (state != ST_IDLE);
  assign rasN       = !((state == ST_RAS_LOW) || (state == ST_SELF_HOLD));
  assign casN       = !((state == ST_CAS_SETUP) || (state == ST_SELF_HOLD) ||
                        ((state == ST_RAS_LOW) && !cycRo));
  assign addrDrive  = (state == ST_RAS_LOW) && cycRo;
  assign selfActive = (state == ST_SELF_HOLD);

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
  import refr_pkg::*;
#(
  parameter int ROWS_SMALL = 2048,
  parameter int ROWS_LARGE = 4096,
  parameter int IV_W       = 16,
  parameter int PEND_MAX   = 4,
  parameter int CSR_CYC    = 2,
  parameter int RAS_CYC    = 4,
  parameter int RP_CYC     = 3,
  parameter int SELF_CYC   = 10,
  parameter int RPS_CYC    = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          refreshEn,
  input  logic [IV_W-1:0]               intervalCycles,
  input  logic                          mode4k,
  input  logic                          useRasOnly,
  input  logic                          selfReq,
  input  logic                          refGnt,
  output logic                          refReq,
  output logic                          rasN,
  output logic                          casN,
  output logic                          weN,
  output logic                          oeN,
  output logic                          addrDrive,
  output logic [$clog2(ROWS_LARGE)-1:0] rowAddr,
  output logic                          selfActive
);

  localparam int ROW_W = $clog2(ROWS_LARGE);

  dpCtrl_t ctl;
  dpStat_t stat;

  refr_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .refreshEn  (refreshEn),
    .useRasOnly (useRasOnly),
    .selfReq    (selfReq),
    .refGnt     (refGnt),
    .stat       (stat),
    .ctl        (ctl),
    .refReq     (refReq),
    .rasN       (rasN),
    .casN       (casN),
    .addrDrive  (addrDrive),
    .selfActive (selfActive)
  );

  refr_datapath #(
    .ROWS_SMALL (ROWS_SMALL),
    .ROWS_LARGE (ROWS_LARGE),
    .IV_W       (IV_W),
    .PEND_MAX   (PEND_MAX),
    .CSR_CYC    (CSR_CYC),
    .RAS_CYC    (RAS_CYC),
    .RP_CYC     (RP_CYC),
    .SELF_CYC   (SELF_CYC),
    .RPS_CYC    (RPS_CYC)
  ) u_dp (
    .clk            (clk),
    .rstN           (rstN),
    .refreshEn      (refreshEn),
    .intervalCycles (intervalCycles),
    .mode4k         (mode4k),
    .ctl            (ctl),
    .stat           (stat),
    .rowAddr        (rowAddr)
  );

  // refresh never writes and never reads data
  assign weN = 1'b1;
  assign oeN = 1'b1;

endmodule

// File: rtl/refr_checker.sv
module refr_checker #(
  parameter int ROWS_SMALL = 2048,
  parameter int ROWS_LARGE = 4096,
  parameter int ROW_W      = 12
) (
  input logic             clk,
  input logic             rstN,
  input logic             refReq,
  input logic             refGnt,
  input logic             rasN,
  input logic             casN,
  input logic             addrDrive,
  input logic             selfActive,
  input logic             mode4k,
  input logic [ROW_W-1:0] rowAddr
);

  logic [ROW_W-1:0] rowLastNow;
  assign rowLastNow = mode4k ? ROW_W'(ROWS_LARGE - 1) : ROW_W'(ROWS_SMALL - 1);

  assert_strobe_owned_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN) |-> (refReq && refGnt));

  assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && !casN) |-> !$past(casN));

  assert_rasonly_drives_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rasN) && casN) |-> addrDrive);

  assert_addr_window_R5: assert property (@(posedge clk) disable iff (!rstN)
    addrDrive |-> (!rasN && casN));

  assert_row_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rowAddr != $past(rowAddr)) |->
      (rowAddr == (($past(rowAddr) == $past(rowLastNow)) ? '0 : ROW_W'($past(rowAddr) + 1'b1))));

  assert_release_high_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(refReq) |-> (rasN && casN && $past(rasN) && $past(casN)));

  assert_self_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    selfActive |-> (!rasN && !casN && refReq));

endmodule

bind dram_refresh_ctrl refr_checker #(
  .ROWS_SMALL (ROWS_SMALL),
  .ROWS_LARGE (ROWS_LARGE),
  .ROW_W      (ROW_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .refReq     (refReq),
  .refGnt     (refGnt),
  .rasN       (rasN),
  .casN       (casN),
  .addrDrive  (addrDrive),
  .selfActive (selfActive),
  .mode4k     (mode4k),
  .rowAddr    (rowAddr)
);

// File: tb/tb_dram_refresh_ctrl.sv
module tb_dram_refresh_ctrl;

  localparam int CSR  = 2;
  localparam int RASW = 4;
  localparam int RP   = 3;
  localparam int SELF = 10;
  localparam int RPS  = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refreshEn = 1'b0;
  logic [15:0] intervalCycles = 16'd100;
  logic        mode4k = 1'b0;
  logic        useRasOnly = 1'b0;
  logic        selfReq = 1'b0;
  logic        refGnt = 1'b0;
  logic        refReq, rasN, casN, weN, oeN, addrDrive, selfActive;
  logic [11:0] rowAddr;

  dram_refresh_ctrl dut (
    .clk(clk), .rstN(rstN), .refreshEn(refreshEn), .intervalCycles(intervalCycles),
    .mode4k(mode4k), .useRasOnly(useRasOnly), .selfReq(selfReq), .refGnt(refGnt),
    .refReq(refReq), .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN),
    .addrDrive(addrDrive), .rowAddr(rowAddr), .selfActive(selfActive)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int bad = 0;

  task automatic chkEq(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // falling-edge protocol monitor (counters only grow)
  int cbrFalls = 0, roFalls = 0, rowErrs = 0, wraps = 0, protoErrs = 0;
  int reqRises = 0, reqFalls = 0, noGnt = 0;
  int lastRelHigh = 0, lastCasRun = 0, lastRasLow = 0, lastSelfLow = 0, selfExitGap = 0;
  int casLowRun = 0, rasLowRun = 0, rasHighRun = 1000;
  int expRow = 0, prevRoRow = -1, rowsNow = 2048;
  bit prevRas = 1'b1, prevReq = 1'b0, lowHadSelf = 1'b0, leftSelf = 1'b0;

  always @(negedge clk) begin
    if (rstN) begin
      if ((!rasN || !casN) && !refGnt) noGnt++;
      if (!weN || !oeN) protoErrs++;
      if (refReq && !prevReq) reqRises++;
      if (!refReq && prevReq) begin reqFalls++; lastRelHigh = rasHighRun; end
      if (!rasN && prevRas) begin
        if (leftSelf) begin selfExitGap = rasHighRun; leftSelf = 1'b0; end
        if (rasHighRun < RP) protoErrs++;
        if (!casN) begin
          cbrFalls++;
          lastCasRun = casLowRun;
          if (casLowRun != CSR) protoErrs++;
        end else begin
          roFalls++;
          if (!addrDrive) protoErrs++;
          if (int'(rowAddr) != expRow) rowErrs++;
          if (rowAddr == 0 && prevRoRow == rowsNow - 1) wraps++;
          prevRoRow = int'(rowAddr);
          expRow = (int'(rowAddr) + 1) % rowsNow;
        end
      end
      if (rasN && !prevRas) begin
        if (lowHadSelf) begin lastSelfLow = rasLowRun; leftSelf = 1'b1; end
        else begin
          lastRasLow = rasLowRun;
          if (rasLowRun != RASW) protoErrs++;
        end
      end
      if (!rasN) begin
        rasLowRun  = prevRas ? 1 : rasLowRun + 1;
        lowHadSelf = prevRas ? selfActive : (lowHadSelf | selfActive);
        rasHighRun = 0;
      end else begin
        rasHighRun++;
        rasLowRun = 0;
      end
      casLowRun = (!casN && rasN) ? casLowRun + 1 : 0;
      prevRas = rasN;
      prevReq = refReq;
    end
  end

  task automatic waitRelease();
    while (refReq) @(negedge clk);
    refreshEn = 1'b0;
    @(negedge clk);
  endtask

  task automatic testReset();
    chkEq("R1", "refReq", refReq, 0);
    chkEq("R1", "rasN", rasN, 1);
    chkEq("R1", "casN", casN, 1);
    chkEq("R1", "addrDrive", addrDrive, 0);
    chkEq("R1", "selfActive", selfActive, 0);
    chkEq("R1", "rowAddr", rowAddr, 0);
  endtask

  task automatic testTimerCbr();
    int firstReq = 0;
    int c0 = cbrFalls, p0 = protoErrs;
    intervalCycles = 16'd40; refGnt = 1'b1; useRasOnly = 1'b0;
    refreshEn = 1'b1;
    for (int i = 1; i <= 45; i++) begin
      @(negedge clk);
      if (refReq && firstReq == 0) firstReq = i;
    end
    chkEq("R2", "cycles to first request", firstReq, 41);
    waitRelease();
    chkEq("R4", "column-first cycles", cbrFalls - c0, 1);
    chkEq("R4", "cas setup samples", lastCasRun, CSR);
    chkEq("R4", "ras low samples", lastRasLow, RASW);
    chkEq("R7", "high samples before release", lastRelHigh, RP);
    chkEq("R4", "protocol errors", protoErrs - p0, 0);
  endtask

  task automatic testGrantWait();
    int c0 = cbrFalls, f0 = reqFalls;
    refGnt = 1'b0; intervalCycles = 16'd30; refreshEn = 1'b1;
    repeat (31) @(negedge clk);
    chkEq("R3", "request while waiting", refReq, 1);
    repeat (35) @(negedge clk);
    chkEq("R3", "rasN before grant", rasN, 1);
    chkEq("R3", "casN before grant", casN, 1);
    chkEq("R3", "cycles before grant", cbrFalls - c0, 0);
    refGnt = 1'b1;
    @(negedge clk);
    chkEq("R3", "casN one cycle after grant", casN, 0);
    waitRelease();
    chkEq("R6", "two stored requests served", cbrFalls - c0, 2);
    chkEq("R6", "single ownership", reqFalls - f0, 1);
  endtask

  task automatic testBacklog();
    int c0 = cbrFalls, f0 = reqFalls;
    refGnt = 1'b0; intervalCycles = 16'd200; refreshEn = 1'b1;
    repeat (1250) @(negedge clk);
    refGnt = 1'b1;
    waitRelease();
    chkEq("R6", "saturated backlog cycles", cbrFalls - c0, 4);
    chkEq("R6", "back to back ownership", reqFalls - f0, 1);
  endtask

  task automatic testRasOnly();
    int r0 = roFalls, c0 = cbrFalls, e0 = rowErrs;
    mode4k = 1'b0; rowsNow = 2048; useRasOnly = 1'b1;
    refGnt = 1'b1; intervalCycles = 16'd12; refreshEn = 1'b1;
    repeat (66) @(negedge clk);
    waitRelease();
    chkEq("R5", "row-only cycles", roFalls - r0, 5);
    chkEq("R5", "column-first cycles", cbrFalls - c0, 0);
    chkEq("R5", "row sequence errors", rowErrs - e0, 0);
    chkEq("R5", "row after five cycles", rowAddr, 5);
    chkEq("R5", "ras low samples", lastRasLow, RASW);
  endtask

  task automatic testDisabled();
    int q0 = reqRises;
    refreshEn = 1'b0; refGnt = 1'b1; intervalCycles = 16'd10;
    repeat (300) @(negedge clk);
    chkEq("R2", "requests while disabled", reqRises - q0, 0);
  endtask

  task automatic testSelfShortRasOnly();
    int r0 = roFalls, c0 = cbrFalls, e0 = rowErrs, w0 = wraps;
    int startRow;
    mode4k = 1'b0; rowsNow = 2048; useRasOnly = 1'b1; refreshEn = 1'b0; refGnt = 1'b1;
    startRow = int'(rowAddr);
    selfReq = 1'b1;
    while (!selfActive) @(negedge clk);
    selfReq = 1'b0;
    waitRelease();
    chkEq("R8", "minimum self low samples", lastSelfLow, SELF);
    chkEq("R9", "gap after self exit", selfExitGap, RPS);
    chkEq("R9", "row-only burst length", roFalls - r0, 2048);
    chkEq("R8", "entry cycles", cbrFalls - c0, 1);
    chkEq("R5", "burst row errors", rowErrs - e0, 0);
    chkEq("R5", "wraps at 2047", wraps - w0, 1);
    chkEq("R9", "row after full sweep", rowAddr, startRow);
  endtask

  task automatic testSelfLongCbr();
    int r0 = roFalls, c0 = cbrFalls;
    int holdBad = 0;
    mode4k = 1'b1; rowsNow = 4096; useRasOnly = 1'b0; refreshEn = 1'b0; refGnt = 1'b1;
    selfReq = 1'b1;
    while (!selfActive) @(negedge clk);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!selfActive || rasN || casN) holdBad++;
    end
    selfReq = 1'b0;
    waitRelease();
    chkEq("R8", "hold while commanded", holdBad, 0);
    chkEq("R8", "long self low samples", lastSelfLow, 21);
    chkEq("R9", "gap after self exit", selfExitGap, RPS + CSR);
    chkEq("R9", "column-first burst plus entry", cbrFalls - c0, 4097);
    chkEq("R9", "row-only cycles", roFalls - r0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testTimerCbr();
    testGrantWait();
    testBacklog();
    testRasOnly();
    testDisabled();
    testSelfShortRasOnly();
    testSelfLongCbr();
    chkEq("R3", "strobe active without grant", noGnt, 0);
    chkEq("R4", "total protocol errors", protoErrs, 0);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule